// File: doc/BRIEF.md
# Cascaded DMA Request Arbiter

This block decides which of eight DMA channels gets the bus. The channels sit on two four-channel controllers: a byte-wide lower controller for channels 0 to 3, and a word-wide upper controller for channels 4 to 7. The whole lower controller feeds the upper controller through channel 4. Channel 4 is kept as that cascade link and cannot be requested directly. The block takes the request bits, mask bits and disable bit of each controller. From these it drives a hold request toward the processor.

When the processor answers with hold-acknowledge, the block resolves a winner in two levels. First the upper controller picks its best unmasked requester. If that is the cascade channel, the lower controller then picks its own best unmasked channel. The block reports the winning controller and channel and drives one-hot acknowledge lines for both controllers. Programming of the controller registers and all address and count arithmetic belong to neighbouring logic.

Top module: `dma_cascade_arbiter`

## Requirements
- R1: Within a controller the lowest-numbered competing channel wins, so channel 0 has the highest priority and channel 3 the lowest.
- R2: A channel whose mask bit is 1 never wins a grant and never raises the hold request or the cascade request.
- R3: While `lo_disable` is 0, `cascade_req` updates on each clock edge. It becomes 0 when `lo_req` is all zero. It becomes 1 when some bit of `lo_req & ~lo_mask` is set. Otherwise, when requests are present but all are masked, it keeps its value.
- R4: While `hi_disable` is 0, `hold_req` follows the same rule over the upper request vector. Bit 0 of that vector is `cascade_req`, and bits 1 to 3 are `hi_req[0]` to `hi_req[2]` (channels 5 to 7).
- R5: While a controller's disable bit is 1, its output (`cascade_req` for the lower, `hold_req` for the upper) holds its value regardless of requests and masks.
- R6: The grant outputs are registered. `grant_valid` appears one clock after `hlda` is sampled high. For an upper-controller winner on channel n (n = 1 to 3), the outputs are `grant_hi` = 1, `grant_chan` = n, `hi_dack` = one-hot bit n and `lo_dack` = 0.
- R7: When the upper winner is the cascade channel and the lower controller has an unmasked requester m, the outputs are `grant_hi` = 0, `grant_chan` = m, `hi_dack` = 4'b0001 and `lo_dack` = one-hot bit m.
- R8: If no unmasked requester exists at hold-acknowledge, `grant_valid` stays 0 and both acknowledge vectors stay 0. This also holds when the cascade channel wins but every lower request is masked.
- R9: One clock after `hlda` is sampled low, `grant_valid`, `lo_dack` and `hi_dack` are all 0.
- R10: After a clock edge with `rst_n` low, `cascade_req`, `hold_req`, `grant_valid` and both acknowledge vectors are 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lo_req | input | NCH | Request bits of the lower controller, channels 0..3 |
| lo_mask | input | NCH | Mask bits of the lower controller; 1 = masked |
| lo_disable | input | 1 | Lower controller disable; freezes `cascade_req` |
| hi_req | input | NCH-1 | Request bits of upper channels 5..7 (bit 0 = channel 5) |
| hi_mask | input | NCH | Mask bits of the upper controller; bit 0 masks the cascade channel |
| hi_disable | input | 1 | Upper controller disable; freezes `hold_req` |
| hlda | input | 1 | Hold-acknowledge from the processor |
| cascade_req | output | 1 | Lower controller's request into upper channel 0 |
| hold_req | output | 1 | Hold request to the processor |
| grant_valid | output | 1 | A channel is granted |
| grant_hi | output | 1 | 1 = granted channel is on the upper controller |
| grant_chan | output | log2(NCH) | Channel index within the granted controller |
| lo_dack | output | NCH | One-hot acknowledge, lower controller |
| hi_dack | output | NCH | One-hot acknowledge, upper controller; bit 0 = cascade |

## Verification
The bench builds the block with the default NCH = 4. This gives the full eight-channel arrangement with three directly requested upper channels plus the cascade link. At that size every priority extreme can be reached from a short table, as can every mix of masked cascade and masked lower channel. That includes the case where the cascade wins at the upper level but nothing below it is unmasked. Directed sequences then cover the hold-on-all-masked rule, freezing through the disable bits, and the one-clock grant timing.

// File: rtl/dma_arb_pkg.sv
// Package: shared types for the cascaded DMA request arbiter.
// Assumes: two controllers only, the upper one owning the cascade channel.
package dma_arb_pkg;

    // Which controller a grant belongs to
    typedef enum logic {
        CTRL_LO = 1'b0,
        CTRL_HI = 1'b1
    } ctrl_sel_e;

endpackage

// File: rtl/dma_prio_pick.sv
// Module: dma_prio_pick
// Fixed-priority picker: bit 0 is the highest priority. Reports whether any
// bit is set, the index of the winner and a one-hot copy of the winner.
// Assumes: N >= 2.
module dma_prio_pick #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);

    // Scan from the lowest priority up so the lowest set index remains
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
        any    = |vec;
        onehot = vec & (~vec + N'(1));
    end

endmodule

// File: rtl/dma_req_ctrl.sv
// Module: dma_req_ctrl
// Request-output register of one controller. Drops when nothing is requested,
// rises when an unmasked request exists, keeps its value when every pending
// request is masked, and freezes completely while the controller is disabled.
// Assumes: synchronous active-low reset.
module dma_req_ctrl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] mask,
    input  logic         disable_i,
    output logic         req_out
);

    logic [N-1:0] live;

    // Requests that may compete
    always_comb live = req & ~mask;

    // Update the controller's outgoing request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_out <= 1'b0;
        end else if (!disable_i) begin
            if (req == '0) begin
                req_out <= 1'b0;
            end else if (live != '0) begin
                req_out <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_grant_unit.sv
// Module: dma_grant_unit
// Two-level winner selection taken when hold-acknowledge is sampled. The upper
// level picks first; a cascade win (upper channel 0) is resolved again in the
// lower controller. The grant and acknowledge lines are registered.
// Assumes: upper bit 0 carries the lower controller's cascade request.
module dma_grant_unit
    import dma_arb_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hlda,
    input  logic [N-1:0]  hi_vec,
    input  logic [N-1:0]  hi_mask,
    input  logic [N-1:0]  lo_vec,
    input  logic [N-1:0]  lo_mask,
    output logic          gnt_valid,
    output ctrl_sel_e     gnt_ctrl,
    output logic [IW-1:0] gnt_chan,
    output logic [N-1:0]  lo_ack,
    output logic [N-1:0]  hi_ack
);

    logic [N-1:0]  hi_live, lo_live;
    logic          hi_any, lo_any;
    logic [IW-1:0] hi_idx, lo_idx;
    logic [N-1:0]  hi_oh, lo_oh;

    // Only unmasked requests compete at either level
    always_comb begin
        hi_live = hi_vec & ~hi_mask;
        lo_live = lo_vec & ~lo_mask;
    end

    dma_prio_pick #(.N(N)) u_pick_hi (
        .vec    (hi_live),
        .any    (hi_any),
        .idx    (hi_idx),
        .onehot (hi_oh)
    );

    dma_prio_pick #(.N(N)) u_pick_lo (
        .vec    (lo_live),
        .any    (lo_any),
        .idx    (lo_idx),
        .onehot (lo_oh)
    );

    // Register the grant; no winner or no acknowledge leaves everything idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            gnt_ctrl  <= CTRL_LO;
            gnt_chan  <= '0;
            lo_ack    <= '0;
            hi_ack    <= '0;
        end else if (hlda && hi_any && (hi_idx != '0)) begin
            gnt_valid <= 1'b1;
            gnt_ctrl  <= CTRL_HI;
            gnt_chan  <= hi_idx;
            lo_ack    <= '0;
            hi_ack    <= hi_oh;
        end else if (hlda && hi_any && lo_any) begin
            gnt_valid <= 1'b1;
            gnt_ctrl  <= CTRL_LO;
            gnt_chan  <= lo_idx;
            lo_ack    <= lo_oh;
            hi_ack    <= hi_oh;
        end else begin
            gnt_valid <= 1'b0;
            gnt_ctrl  <= CTRL_LO;
            gnt_chan  <= '0;
            lo_ack    <= '0;
            hi_ack    <= '0;
        end
    end

endmodule

// File: rtl/dma_cascade_arbiter.sv
// Module: dma_cascade_arbiter (top)
// Arbitrates a lower and an upper DMA controller joined through upper
// channel 0. Produces the cascade request, the processor hold request and,
// after hold-acknowledge, the registered grant with acknowledge lines.
// Assumes: upper channel 0 is never requested from outside.
module dma_cascade_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] lo_req,
    input  logic [NCH-1:0] lo_mask,
    input  logic           lo_disable,
    input  logic [NCH-2:0] hi_req,
    input  logic [NCH-1:0] hi_mask,
    input  logic           hi_disable,
    input  logic           hlda,
    output logic           cascade_req,
    output logic           hold_req,
    output logic           grant_valid,
    output logic           grant_hi,
    output logic [CW-1:0]  grant_chan,
    output logic [NCH-1:0] lo_dack,
    output logic [NCH-1:0] hi_dack
);

    logic [NCH-1:0] hi_vec;
    ctrl_sel_e      gnt_ctrl;

    // Upper request vector: cascade link in slot 0, external channels above
    always_comb hi_vec = {hi_req, cascade_req};

    dma_req_ctrl #(.N(NCH)) u_lo_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (lo_req),
        .mask      (lo_mask),
        .disable_i (lo_disable),
        .req_out   (cascade_req)
    );

    dma_req_ctrl #(.N(NCH)) u_hi_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (hi_vec),
        .mask      (hi_mask),
        .disable_i (hi_disable),
        .req_out   (hold_req)
    );

    dma_grant_unit #(.N(NCH)) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .hlda      (hlda),
        .hi_vec    (hi_vec),
        .hi_mask   (hi_mask),
        .lo_vec    (lo_req),
        .lo_mask   (lo_mask),
        .gnt_valid (grant_valid),
        .gnt_ctrl  (gnt_ctrl),
        .gnt_chan  (grant_chan),
        .lo_ack    (lo_dack),
        .hi_ack    (hi_dack)
    );

    // Flatten the controller select onto the port
    always_comb grant_hi = (gnt_ctrl == CTRL_HI);

endmodule

// File: rtl/dma_cascade_arbiter_chk.sv
// Module: dma_cascade_arbiter_chk
// Property checker for the cascaded arbiter, attached by bind below.
// Assumes: synchronous active-low reset on the design.
module dma_cascade_arbiter_chk #(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] lo_req,
    input logic [NCH-1:0] lo_mask,
    input logic           lo_disable,
    input logic [NCH-2:0] hi_req,
    input logic [NCH-1:0] hi_mask,
    input logic           hi_disable,
    input logic           hlda,
    input logic           cascade_req,
    input logic           hold_req,
    input logic           grant_valid,
    input logic           grant_hi,
    input logic [CW-1:0]  grant_chan,
    input logic [NCH-1:0] lo_dack,
    input logic [NCH-1:0] hi_dack
);

    a_r1_chan_matches_dack: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_hi) |-> hi_dack[grant_chan]);

    a_r2_masked_never_acked: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((($past(lo_mask) & lo_dack) == '0) && (($past(hi_mask) & hi_dack) == '0)));

    a_r3_idle_drops_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_disable && lo_req == '0) |=> !cascade_req);

    a_r4_idle_drops_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_disable && hi_req == '0 && !cascade_req) |=> !hold_req);

    a_r5_lo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lo_disable |=> $stable(cascade_req));

    a_r5_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hi_disable |=> $stable(hold_req));

    a_r6_direct_grant_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_hi) |-> ($countones(hi_dack) == 1 && !hi_dack[0] && lo_dack == '0));

    a_r7_cascade_grant_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_hi) |-> (hi_dack[0] && $countones(hi_dack) == 1 && $countones(lo_dack) == 1));

    a_r8_idle_no_dack: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (hi_dack == '0 && lo_dack == '0));

    a_r9_no_grant_without_hlda: assert property (@(posedge clk) disable iff (!rst_n)
        !hlda |=> !grant_valid);

endmodule

bind dma_cascade_arbiter dma_cascade_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_req      (lo_req),
    .lo_mask     (lo_mask),
    .lo_disable  (lo_disable),
    .hi_req      (hi_req),
    .hi_mask     (hi_mask),
    .hi_disable  (hi_disable),
    .hlda        (hlda),
    .cascade_req (cascade_req),
    .hold_req    (hold_req),
    .grant_valid (grant_valid),
    .grant_hi    (grant_hi),
    .grant_chan  (grant_chan),
    .lo_dack     (lo_dack),
    .hi_dack     (hi_dack)
);

// File: tb/dma_cascade_arbiter_tb.sv
// Bench for dma_cascade_arbiter: table of vectors, then directed sequences.
module dma_cascade_arbiter_tb;

    localparam int NCH = 4;
    localparam int CW  = $clog2(NCH);
    localparam int NV  = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] lo_req, lo_mask, hi_mask;
    logic [NCH-2:0] hi_req;
    logic           lo_disable, hi_disable, hlda;
    logic           cascade_req, hold_req, grant_valid, grant_hi;
    logic [CW-1:0]  grant_chan;
    logic [NCH-1:0] lo_dack, hi_dack;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dma_cascade_arbiter #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lo_req(lo_req), .lo_mask(lo_mask), .lo_disable(lo_disable),
        .hi_req(hi_req), .hi_mask(hi_mask), .hi_disable(hi_disable),
        .hlda(hlda),
        .cascade_req(cascade_req), .hold_req(hold_req),
        .grant_valid(grant_valid), .grant_hi(grant_hi), .grant_chan(grant_chan),
        .lo_dack(lo_dack), .hi_dack(hi_dack)
    );

    // Vector: lo_req, lo_mask, hi_req, hi_mask, casc, hold,
    //         {valid, hi, chan, lo_dack, hi_dack}
    localparam logic [28:0] TBL [NV] = '{
        {4'b0001, 4'b0000, 3'b000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'b0001, 4'b0001},
        {4'b1010, 4'b0000, 3'b000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'b0010, 4'b0001},
        {4'b1010, 4'b0010, 3'b000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 4'b1000, 4'b0001},
        {4'b0000, 4'b0000, 3'b100, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 4'b0000, 4'b1000},
        {4'b0100, 4'b0000, 3'b011, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 4'b0100, 4'b0001},
        {4'b0100, 4'b0000, 3'b011, 4'b0001, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 4'b0000, 4'b0010},
        {4'b1111, 4'b1110, 3'b111, 4'b0110, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'b0001, 4'b0001},
        {4'b0000, 4'b0000, 3'b000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] grant_word();
        return {grant_valid, grant_hi, grant_chan, lo_dack, hi_dack};
    endfunction

    task automatic drive(input logic [3:0] lr, input logic [3:0] lm,
                         input logic [2:0] hr, input logic [3:0] hm);
        @(negedge clk);
        lo_req  = lr;
        lo_mask = lm;
        hi_req  = hr;
        hi_mask = hm;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        lo_req = '1; lo_mask = '0; hi_req = '1; hi_mask = '0;
        lo_disable = 1'b0; hi_disable = 1'b0; hlda = 1'b1;
        wait_n(3);
        // R10: reset clears everything despite live requests and hlda
        check("R10 cascade_req", 32'(cascade_req), 0);
        check("R10 hold_req",    32'(hold_req), 0);
        check("R10 grant",       32'(grant_word()), 0);
        rst_n = 1'b1;
        hlda  = 1'b0;
        drive(4'b0, 4'b0, 3'b0, 4'b0);
        wait_n(3);

        // Table walk: R1 R2 R3 R4 R6 R7
        for (int v = 0; v < NV; v++) begin
            drive(TBL[v][28:25], TBL[v][24:21], TBL[v][20:18], TBL[v][17:14]);
            wait_n(3);
            check($sformatf("R3 vec%0d cascade_req", v), 32'(cascade_req), 32'(TBL[v][13]));
            check($sformatf("R4 vec%0d hold_req", v),    32'(hold_req),    32'(TBL[v][12]));
            hlda = 1'b1;
            wait_n(1);
            check($sformatf("R1/R2/R6/R7 vec%0d grant", v), 32'(grant_word()), 32'(TBL[v][11:0]));
            hlda = 1'b0;
            wait_n(1);
        end

        // R3: all pending lower requests masked keeps cascade_req high
        drive(4'b0001, 4'b0000, 3'b000, 4'b0000);
        wait_n(3);
        check("R3 raise", 32'(cascade_req), 1);
        lo_mask = 4'b0001;
        wait_n(3);
        check("R3 keep when all masked", 32'(cascade_req), 1);
        check("R4 hold follows cascade", 32'(hold_req), 1);
        // R8: cascade wins upper level but nothing below is unmasked
        hlda = 1'b1;
        wait_n(1);
        check("R8 cascade with masked lower", 32'(grant_word()), 0);
        hlda = 1'b0;
        lo_req = 4'b0000;
        wait_n(3);
        check("R3 drop on no request", 32'(cascade_req), 0);
        check("R4 drop on no request", 32'(hold_req), 0);

        // R4: all pending upper requests masked keeps hold_req high
        drive(4'b0000, 4'b0000, 3'b001, 4'b0000);
        wait_n(3);
        check("R4 raise", 32'(hold_req), 1);
        hi_mask = 4'b1111;
        wait_n(3);
        check("R4 keep when all masked", 32'(hold_req), 1);
        hlda = 1'b1;
        wait_n(1);
        check("R8 all upper masked", 32'(grant_word()), 0);
        hlda = 1'b0;
        drive(4'b0, 4'b0, 3'b0, 4'b0);
        wait_n(3);

        // R5: upper disable freezes hold_req high
        drive(4'b0000, 4'b0000, 3'b001, 4'b0000);
        wait_n(3);
        hi_disable = 1'b1;
        hi_req = 3'b000;
        wait_n(3);
        check("R5 hold frozen high", 32'(hold_req), 1);
        hi_disable = 1'b0;
        wait_n(2);
        check("R5 hold released", 32'(hold_req), 0);

        // R5: lower disable freezes cascade_req low against a new request
        lo_disable = 1'b1;
        lo_req = 4'b0010;
        wait_n(3);
        check("R5 cascade frozen low", 32'(cascade_req), 0);
        lo_disable = 1'b0;
        wait_n(1);
        check("R5 cascade released", 32'(cascade_req), 1);
        lo_disable = 1'b1;
        lo_req = 4'b0000;
        wait_n(3);
        check("R5 cascade frozen high", 32'(cascade_req), 1);
        lo_disable = 1'b0;
        wait_n(3);

        // R6 timing and R9 release: channel 7 direct grant
        drive(4'b0000, 4'b0000, 3'b100, 4'b0000);
        wait_n(3);
        hlda = 1'b1;
        @(posedge clk);
        #1;
        check("R6 grant one clock after hlda", 32'(grant_word()), 32'({1'b1, 1'b1, 2'd3, 4'b0000, 4'b1000}));
        @(negedge clk);
        hlda = 1'b0;
        wait_n(1);
        check("R9 grant cleared", 32'(grant_word()), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule